// File: doc/BRIEF.md
# Right-Shifting Register with Sign-Fill Option

This block is an eight-bit storage register made of eight identical bit slices. Each slice pairs one flip-flop with two 2-to-1 selectors. The inner selector decides whether the slice takes its left neighbour's bit or keeps its own. The outer selector decides whether that result or a parallel load bit reaches the flip-flop. Together the slices provide a parallel load, a hold, and a one-position right shift on every rising clock edge.

The leftmost slice has no neighbour, so a small fill circuit supplies its shift input. With the sign option clear, a zero enters at the top (logical shift). With the sign option set, the top bit copies itself (arithmetic shift), which keeps the sign of a two's-complement value. Reset is synchronous and active-low. Reset takes priority over load, and load takes priority over shift.

Top module: `sgn_shift_reg`

## Requirements
- R1: When rst_n is 0 at a rising clock edge, q becomes 8'h00 on that edge, whatever the other inputs are.
- R2: When rst_n is 1 and ld_n is 0 at a rising edge, q takes ld_val on that edge, whatever shr_en and sign_fill are.
- R3: When rst_n is 1, ld_n is 1 and shr_en is 0 at a rising edge, q keeps its value.
- R4: When rst_n is 1, ld_n is 1 and shr_en is 1, each bit q[i] for i from 0 to 6 takes the previous q[i+1] on the edge.
- R5: During a shift with sign_fill equal to 0, q[7] becomes 0. Two shifts of A therefore give {0,0,A[7:2]}.
- R6: During a shift with sign_fill equal to 1, q[7] keeps its value. Two shifts of A therefore give {A7,A7,A7,A[6:2]}.
- R7: Eight or more logical shifts leave q at 8'h00. Seven or more arithmetic shifts of a value with q[7] equal to 1 leave q at 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_n | input | 1 | Parallel load, active low |
| shr_en | input | 1 | Right-shift enable |
| sign_fill | input | 1 | 1 selects arithmetic fill of the top bit, 0 selects zero fill |
| ld_val | input | 8 | Parallel load value |
| q | output | 8 | Register contents |

## Verification
The properties compare q against its value on the previous edge, so they take for granted that the control inputs are stable around each rising edge. They also assume the first checked edge comes after reset has been released. The bench changes every input only on the falling clock edge, and it holds rst_n low for the first edges. Through this pattern, load, hold and both shift kinds follow one another in varied orders and with varied data, with no violation of these assumptions.

// File: rtl/sgn_shift_pkg.sv
// Package: shared width for the shift register and its helpers.
package sgn_shift_pkg;
    localparam int unsigned DEF_WIDTH = 8;

    // Fill modes for the top bit.
    typedef enum logic {
        FILL_ZERO = 1'b0,
        FILL_SIGN = 1'b1
    } fill_mode_e;
endpackage

// File: rtl/sgn_mux2.sv
// Module: two-input selector, one bit wide.
// Assumes: sel is a known value; output follows a when sel=0, b when sel=1.
module sgn_mux2 (
    input  logic a,
    input  logic b,
    input  logic sel,
    output logic y
);
    // Purpose: pick one of two inputs.
    always_comb begin
        y = sel ? b : a;
    end
endmodule

// File: rtl/sgn_dff.sv
// Module: single flip-flop with synchronous active-low clear.
// Assumes: rst_n is sampled only at the rising edge.
module sgn_dff (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    // Purpose: store d on each rising edge, clear while rst_n is low.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
    end
endmodule

// File: rtl/sgn_shift_cell.sv
// Module: one register slice. The inner selector chooses between hold and the
// neighbour's bit. The outer selector lets the load value override that choice.
// Assumes: nb_in comes from the slice to the left (or the fill logic).
module sgn_shift_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_n,
    input  logic shr_en,
    input  logic ld_bit,
    input  logic nb_in,
    output logic q
);
    logic shift_pick;
    logic d_next;

    sgn_mux2 u_shift_sel (.a(q),      .b(nb_in),      .sel(shr_en), .y(shift_pick));
    sgn_mux2 u_load_sel  (.a(ld_bit), .b(shift_pick), .sel(ld_n),   .y(d_next));
    sgn_dff  u_ff        (.clk(clk),  .rst_n(rst_n),  .d(d_next),   .q(q));
endmodule

// File: rtl/sgn_shift_reg.sv
// Module: right-shifting register of W slices with a selectable top-bit fill.
// Priority: reset, then load, then shift, then hold.
// Assumes: all control inputs are synchronous to clk.
module sgn_shift_reg #(
    parameter int unsigned W = sgn_shift_pkg::DEF_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_n,
    input  logic         shr_en,
    input  logic         sign_fill,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] q
);
    localparam int unsigned TOP = W - 1;

    logic [W-1:0] nb;
    logic         top_fill;

    // Purpose: the bit shifted into the top slice, either zero or its own sign.
    always_comb begin
        top_fill = (sgn_shift_pkg::fill_mode_e'(sign_fill) == sgn_shift_pkg::FILL_SIGN) ? q[TOP] : 1'b0;
    end

    // Each slice takes its input from the slice on its left.
    for (genvar i = 0; i < W; i++) begin : g_cell
        if (i == TOP) begin : g_top
            assign nb[i] = top_fill;
        end else begin : g_mid
            assign nb[i] = q[i+1];
        end
        sgn_shift_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .ld_n  (ld_n),
            .shr_en(shr_en),
            .ld_bit(ld_val[i]),
            .nb_in (nb[i]),
            .q     (q[i])
        );
    end
endmodule

// File: rtl/sgn_shift_reg_chk.sv
// Module: property checker for sgn_shift_reg, attached with bind.
// Assumes: inputs change away from the rising edge.
module sgn_shift_reg_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ld_n,
    input logic         shr_en,
    input logic         sign_fill,
    input logic [W-1:0] ld_val,
    input logic [W-1:0] q
);
    logic seen_edge;
    // Purpose: mark that one edge has passed, so $past is meaningful.
    always_ff @(posedge clk) seen_edge <= 1'b1;

    // R1: reset clears the register.
    a_r1_reset_clears: assert property (@(posedge clk)
        seen_edge && !rst_n |=> q == '0);

    // R2: load takes ld_val.
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |=> q == $past(ld_val));

    // R3: hold keeps the value.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n && !shr_en |=> $stable(q));

    // R4: lower bits take their left neighbour.
    a_r4_shift_body: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n && shr_en |=> q[W-2:0] == $past(q[W-1:1]));

    // R5: logical shift inserts zero.
    a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n && shr_en && !sign_fill |=> !q[W-1]);

    // R6: arithmetic shift keeps the top bit.
    a_r6_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n && shr_en && sign_fill |=> q[W-1] == $past(q[W-1]));
endmodule

bind sgn_shift_reg sgn_shift_reg_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .shr_en(shr_en),
    .sign_fill(sign_fill), .ld_val(ld_val), .q(q)
);

// File: tb/sgn_shift_reg_tb.sv
module sgn_shift_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_n = 1'b1;
    logic       shr_en = 1'b0;
    logic       sign_fill = 1'b0;
    logic [7:0] ld_val = '0;
    logic [7:0] q;

    int checks = 0;
    int errors = 0;
    int model = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    sgn_shift_reg u_dut (.clk(clk), .rst_n(rst_n), .ld_n(ld_n), .shr_en(shr_en),
                         .sign_fill(sign_fill), .ld_val(ld_val), .q(q));

    // Behavioural reference: integer arithmetic, updated at each rising edge.
    always @(posedge clk) begin
        if (!rst_n)      model <= 0;
        else if (!ld_n)  model <= int'(ld_val);
        else if (shr_en) model <= sign_fill ? ((model >= 128) ? (model / 2 + 128) : model / 2)
                                            : model / 2;
    end

    task automatic chk(input string req, input logic [7:0] exp);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s: q=%h expected=%h", req, q, exp);
        end
    endtask

    // Compare against the model every cycle, away from the rising edge.
    always @(negedge clk) if (!done && rst_n) chk("R4", model[7:0]);

    // Apply one cycle of controls on the falling edge, then step past the next rising edge.
    task automatic step(input logic r, input logic l, input logic s, input logic f, input logic [7:0] v);
        @(negedge clk);
        rst_n = r; ld_n = l; shr_en = s; sign_fill = f; ld_val = v;
        @(posedge clk); #1;
    endtask

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog: expired expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(0, 0, 1, 1, 8'hA5); chk("R1", 8'h00);
        step(1, 0, 1, 1, 8'hB6); chk("R2", 8'hB6);
        step(1, 1, 0, 1, 8'h00); chk("R3", 8'hB6);
        step(1, 1, 0, 0, 8'h33); chk("R3", 8'hB6);
        step(1, 1, 1, 0, 8'h00); chk("R5", 8'h5B);
        step(1, 1, 1, 0, 8'h00); chk("R5", 8'h2D);
        step(1, 0, 0, 0, 8'hC4); chk("R2", 8'hC4);
        step(1, 1, 1, 1, 8'h00); chk("R6", 8'hE2);
        step(1, 1, 1, 1, 8'h00); chk("R6", 8'hF1);
        step(1, 0, 1, 1, 8'h4C); chk("R2", 8'h4C);
        step(1, 1, 1, 1, 8'h00); chk("R6", 8'h26);
        step(1, 0, 0, 0, 8'h81);
        for (int i = 0; i < 7; i++) step(1, 1, 1, 1, 8'h00);
        chk("R7", 8'hFF);
        for (int i = 0; i < 8; i++) step(1, 1, 1, 0, 8'h00);
        chk("R7", 8'h00);
        step(1, 0, 0, 0, 8'h7E); chk("R2", 8'h7E);
        step(0, 0, 1, 0, 8'h11); chk("R1", 8'h00);
        step(1, 0, 0, 0, 8'hFF); chk("R2", 8'hFF);
        step(0, 1, 0, 0, 8'h00); chk("R1", 8'h00);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule